// File: doc/BRIEF.md
# Depth-Cascadable FIFO Slice

This block is a first-in first-out buffer slice with a parameterised word width (nine bits by default) and depth. It works either as a standalone buffer or as one link in a ring of identical slices that together act as one deeper buffer. The slice runs on a single clock. Writes and reads are requested with enables that are sampled on the rising edge, not with free-running strobes.

In a ring, the right to write and the right to read are two separate tokens. Each token travels from slice to slice on a one-cycle, active-low expansion pulse. A kind bit on the pulse says which token it carries. The slice that holds the write token stores incoming words. When it fills its last physical location, it hands the write token to the next slice, which starts writing at its location zero. The read token moves along the ring in the same way.

The mode is fixed during reset. If the expansion input is held low through reset, the slice runs standalone. In standalone mode it also provides a half-full flag and a retransmit control, which rewinds reading to location zero. Combining the per-slice flags into composite flags is done outside the slice.

Top module: `fifo_slice`

## Requirements
- R1: If `xin_n` is low throughout reset, the slice runs standalone. It stores up to DEPTH words, returns them in write order, and holds `xout_n` high.
- R2: A write is accepted only when `full_n` was high before the clock edge. `full_n` is low exactly when the slice holds DEPTH words. A write while full changes no stored word and no count.
- R3: A read is accepted only when `empty_n` was high before the clock edge. `empty_n` is low exactly when the slice holds no words. A read request while empty leaves `rd_data` and the flags unchanged.
- R4: In standalone mode, `half_n` is low exactly when the word count is greater than DEPTH/2 (integer division).
- R5: In standalone mode, a `retrans` cycle does three things. It moves the read position to location 0 and leaves the write position as it was. It sets the count to the write position, or to DEPTH when the slice was full with the write position at 0. It ignores any write or read requested in the same cycle.
- R6: In ring mode, after reset, the slice with `first_n` low holds both the write and read tokens and every other slice holds neither. A slice without the matching token ignores `wr_en` or `rd_en`.
- R7: A ring-mode write to the last location does two things. In the next cycle, `xout_n` goes low for one cycle with `xout_kind` = 0, and the slice gives up its write token. A slice that sees `xin_n` low with `xin_kind` = 0 may accept a write to its location 0 in that same cycle.
- R8: A ring-mode read of the last location does two things. In the next cycle, `xout_n` goes low for one cycle with `xout_kind` = 1, and the slice gives up its read token. A slice that sees `xin_n` low with `xin_kind` = 1 may read its location 0 in that same cycle. A slice never wraps its write and read positions in the same cycle.
- R9: In ring mode, `retrans` has no effect and `half_n` stays high.
- R10: A ring of slices behaves as one buffer of (slices × DEPTH) words in write order. The composite full flag (the OR of all `full_n`) is low only when every slice is full. The composite empty flag (the OR of all `empty_n`) is low only when every slice is empty.
- R11: The flags show the count from the first cycle after the edge that changed it. `rd_data` shows the word in the cycle after an accepted read and holds it until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the mode is sampled while it is high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full_n | output | 1 | Low when the slice holds DEPTH words |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Last word read (registered) |
| empty_n | output | 1 | Low when the slice holds no words |
| half_n | output | 1 | Low when more than half full (standalone only) |
| retrans | input | 1 | Rewind reading to location 0 (standalone only) |
| first_n | input | 1 | Low on the slice that starts with both tokens |
| xin_n | input | 1 | Incoming token pulse, active low; held low through reset to select standalone mode |
| xin_kind | input | 1 | Kind of incoming pulse: 0 write token, 1 read token |
| xout_n | output | 1 | Outgoing token pulse, active low |
| xout_kind | output | 1 | Kind of outgoing pulse: 0 write token, 1 read token |

## Verification
Some properties are checked on every clock. Pointers hold while the blocking flag is low. The count never goes past the depth. `full_n` and `empty_n` are never low at the same time. Each wrap is followed by a hand-off pulse of the right kind, and no slice wraps both positions at once. Retransmit lands the read position on zero. In ring mode `half_n` stays high.

Other behaviour can only be shown by the bench's scenarios running against its reference model. These are the data order, through write and read flow-through at the full and empty edges and through a token crossing between two linked slices. They also include the exact count after a retransmit and the composite flags of a two-slice ring.

// File: rtl/fifo_slice_pkg.sv
package fifo_slice_pkg;
  // Kind bit carried with an expansion pulse
  typedef enum logic {
    HAND_WRITE = 1'b0,
    HAND_READ  = 1'b1
  } hand_kind_t;
endpackage

// File: rtl/slice_mem.sv
// Simple dual-port storage with a registered read port (block RAM friendly)
module slice_mem #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/slice_ptrs.sv
// Write/read positions, word count and registered flags
module slice_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          solo,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          rt_req,
  input  logic          wtok,
  input  logic          rtok,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic          wr_last,
  output logic          rd_last,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_n
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [CW-1:0] cnt, cnt_nx;
  logic          rt_do;

  assign rt_do   = rt_req & solo;
  assign wr_ok   = wr_req & full_n & wtok & ~rt_do;
  assign rd_ok   = rd_req & empty_n & rtok & ~rt_do;
  assign wr_last = wr_ok & (wptr == LAST);
  assign rd_last = rd_ok & (rptr == LAST);

  always_comb begin
    if (rt_do) begin
      if (wptr == '0 && !full_n) cnt_nx = FULL_CNT;
      else                       cnt_nx = CW'(wptr);
    end else begin
      cnt_nx = cnt + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      full_n  <= 1'b1;
      empty_n <= 1'b0;
      half_n  <= 1'b1;
    end else begin
      if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rt_do)      rptr <= '0;
      else if (rd_ok) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      cnt     <= cnt_nx;
      full_n  <= (cnt_nx != FULL_CNT);
      empty_n <= (cnt_nx != '0);
      half_n  <= solo ? !(cnt_nx > HALF_CNT) : 1'b1;
    end
  end

  // R2: a full slice keeps its write position
  assert_full_holds_wptr_R2: assert property (@(posedge clk) disable iff (rst)
    !full_n |=> $stable(wptr));
  // R2: the count stays within the depth
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);
  // R3: an empty slice keeps its read position unless rewound
  assert_empty_holds_rptr_R3: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && !rt_do) |=> $stable(rptr));
  // R11: full and empty never show together
  assert_flag_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !((!full_n) && (!empty_n)));
  // R5: retransmit rewinds reading and keeps writing position
  assert_retrans_rewind_R5: assert property (@(posedge clk) disable iff (rst)
    rt_do |=> (rptr == '0) && $stable(wptr));
  // R9: no half-full indication in ring mode
  assert_half_idle_ring_R9: assert property (@(posedge clk) disable iff (rst)
    !solo |=> half_n);
endmodule

// File: rtl/slice_link.sv
// Mode latch and token ownership, expansion pulse generation
module slice_link
  import fifo_slice_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic first_n,
  input  logic xin_n,
  input  logic xin_kind,
  input  logic wr_last,
  input  logic rd_last,
  output logic solo,
  output logic wtok,
  output logic rtok,
  output logic xout_n,
  output logic xout_kind
);
  logic wheld, rheld;
  logic arrive_w, arrive_r;

  assign arrive_w = !solo && !xin_n && (xin_kind == HAND_WRITE);
  assign arrive_r = !solo && !xin_n && (xin_kind == HAND_READ);
  assign wtok     = wheld | arrive_w;
  assign rtok     = rheld | arrive_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      solo      <= !xin_n;
      wheld     <= !xin_n | !first_n;
      rheld     <= !xin_n | !first_n;
      xout_n    <= 1'b1;
      xout_kind <= HAND_WRITE;
    end else begin
      xout_n <= 1'b1;
      if (!solo) begin
        if (wr_last)       wheld <= 1'b0;
        else if (arrive_w) wheld <= 1'b1;
        if (rd_last)       rheld <= 1'b0;
        else if (arrive_r) rheld <= 1'b1;
        if (wr_last) begin
          xout_n    <= 1'b0;
          xout_kind <= HAND_WRITE;
        end else if (rd_last) begin
          xout_n    <= 1'b0;
          xout_kind <= HAND_READ;
        end
      end
    end
  end

  // R1: a standalone slice never emits a hand-off
  assert_solo_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    solo |-> xout_n);
  // R7: a write wrap is followed by a write-kind pulse and loss of the right
  assert_write_handoff_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_last && !solo) |=> (!xout_n && xout_kind == HAND_WRITE && !wheld));
  // R8: a read wrap is followed by a read-kind pulse and loss of the right
  assert_read_handoff_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_last && !solo) |=> (!xout_n && xout_kind == HAND_READ && !rheld));
  // R8: both positions never wrap in one cycle
  assert_single_handoff_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_last && rd_last));
endmodule

// File: rtl/fifo_slice.sv
module fifo_slice #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty_n,
  output logic              half_n,
  input  logic              retrans,
  input  logic              first_n,
  input  logic              xin_n,
  input  logic              xin_kind,
  output logic              xout_n,
  output logic              xout_kind
);
  logic          solo, wtok, rtok;
  logic          wr_ok, rd_ok, wr_last, rd_last;
  logic [AW-1:0] wptr, rptr;

  slice_link u_link (
    .clk       (clk),
    .rst       (rst),
    .first_n   (first_n),
    .xin_n     (xin_n),
    .xin_kind  (xin_kind),
    .wr_last   (wr_last),
    .rd_last   (rd_last),
    .solo      (solo),
    .wtok      (wtok),
    .rtok      (rtok),
    .xout_n    (xout_n),
    .xout_kind (xout_kind)
  );

  slice_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .solo    (solo),
    .wr_req  (wr_en),
    .rd_req  (rd_en),
    .rt_req  (retrans),
    .wtok    (wtok),
    .rtok    (rtok),
    .wr_ok   (wr_ok),
    .rd_ok   (rd_ok),
    .wr_last (wr_last),
    .rd_last (rd_last),
    .wptr    (wptr),
    .rptr    (rptr),
    .full_n  (full_n),
    .empty_n (empty_n),
    .half_n  (half_n)
  );

  slice_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wptr),
    .wdata (wr_data),
    .re    (rd_ok),
    .raddr (rptr),
    .rdata (rd_data)
  );
endmodule

// File: tb/fifo_slice_test.sv
module fifo_slice_test;
  localparam int D = 16;
  localparam int LIMIT = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  // standalone unit
  logic       s_wr = 0, s_rd = 0, s_rt = 0;
  logic [8:0] s_wd = '0;
  logic [8:0] s_q;
  logic       s_full_n, s_empty_n, s_half_n, s_xo_n, s_xo_k;

  fifo_slice uut (
    .clk(clk), .rst(rst), .wr_en(s_wr), .wr_data(s_wd), .full_n(s_full_n),
    .rd_en(s_rd), .rd_data(s_q), .empty_n(s_empty_n), .half_n(s_half_n),
    .retrans(s_rt), .first_n(1'b0), .xin_n(1'b0), .xin_kind(1'b0),
    .xout_n(s_xo_n), .xout_kind(s_xo_k)
  );

  // two-slice ring
  logic       c_wr = 0, c_rd = 0, c_rt = 0;
  logic [8:0] c_wd = '0;
  logic [8:0] q0, q1;
  logic       f0, f1, e0, e1, h0, h1, x0, x1, k0, k1;

  fifo_slice c0 (
    .clk(clk), .rst(rst), .wr_en(c_wr), .wr_data(c_wd), .full_n(f0),
    .rd_en(c_rd), .rd_data(q0), .empty_n(e0), .half_n(h0),
    .retrans(c_rt), .first_n(1'b0), .xin_n(x1), .xin_kind(k1),
    .xout_n(x0), .xout_kind(k0)
  );
  fifo_slice c1 (
    .clk(clk), .rst(rst), .wr_en(c_wr), .wr_data(c_wd), .full_n(f1),
    .rd_en(c_rd), .rd_data(q1), .empty_n(e1), .half_n(h1),
    .retrans(c_rt), .first_n(1'b1), .xin_n(x0), .xin_kind(k0),
    .xout_n(x1), .xout_kind(k1)
  );

  int nchk = 0, nfail = 0, ncyc = 0, seq = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // ---------------- reference models ----------------
  int sm_mem[D];
  int sm_wp, sm_rp, sm_cnt, sm_exp;
  bit sm_seen;

  int cq[$];
  int cc[2];
  int cws, cwl, crs, crl;
  int cexp[2];
  bit cseen[2];
  bit cxv[2];
  int cxk[2];

  always @(posedge clk) begin
    int wok, rok, v;
    if (rst) begin
      sm_wp = 0; sm_rp = 0; sm_cnt = 0; sm_seen = 0;
      cq.delete(); cc[0] = 0; cc[1] = 0;
      cws = 0; cwl = 0; crs = 0; crl = 0;
      cseen[0] = 0; cseen[1] = 0; cxv[0] = 0; cxv[1] = 0;
      cxk[0] = 0; cxk[1] = 0;
    end else begin
      // standalone
      wok = (s_wr && sm_cnt < D && !s_rt) ? 1 : 0;
      rok = (s_rd && sm_cnt > 0 && !s_rt) ? 1 : 0;
      if (s_rt) begin
        sm_cnt = (sm_wp == 0 && sm_cnt == D) ? D : sm_wp;
        sm_rp = 0;
      end else begin
        if (rok != 0) begin
          sm_exp = sm_mem[sm_rp]; sm_seen = 1;
          sm_rp = (sm_rp + 1) % D; sm_cnt--;
        end
        if (wok != 0) begin
          sm_mem[sm_wp] = int'(s_wd);
          sm_wp = (sm_wp + 1) % D; sm_cnt++;
        end
      end
      // ring (retrans ignored)
      cxv[0] = 0; cxv[1] = 0;
      wok = (c_wr && cc[cws] < D) ? 1 : 0;
      rok = (c_rd && cc[crs] > 0) ? 1 : 0;
      if (rok != 0) begin
        v = cq.pop_front();
        cexp[crs] = v; cseen[crs] = 1; cc[crs]--;
        if (crl == D - 1) begin
          cxv[crs] = 1; cxk[crs] = 1; crl = 0; crs ^= 1;
        end else crl++;
      end
      if (wok != 0) begin
        cq.push_back(int'(c_wd)); cc[cws]++;
        if (cwl == D - 1) begin
          cxv[cws] = 1; cxk[cws] = 0; cwl = 0; cws ^= 1;
        end else cwl++;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 full_n",  int'(s_full_n),  int'(sm_cnt != D));
      chk("R3 empty_n", int'(s_empty_n), int'(sm_cnt != 0));
      chk("R4 half_n",  int'(s_half_n),  int'(!(sm_cnt > D / 2)));
      chk("R1 xout_n",  int'(s_xo_n),    1);
      if (sm_seen) chk("R11 rd_data", int'(s_q), sm_exp);

      chk("R10 c0 full_n",  int'(f0), int'(cc[0] != D));
      chk("R10 c1 full_n",  int'(f1), int'(cc[1] != D));
      chk("R6 c0 empty_n",  int'(e0), int'(cc[0] != 0));
      chk("R6 c1 empty_n",  int'(e1), int'(cc[1] != 0));
      chk("R10 comp full",  int'(f0 | f1), int'((cc[0] + cc[1]) != 2 * D));
      chk("R10 comp empty", int'(e0 | e1), int'((cc[0] + cc[1]) != 0));
      chk("R9 half_n",      int'(h0 & h1), 1);
      chk("R7 c0 xout_n",   int'(x0), int'(!cxv[0]));
      chk("R8 c1 xout_n",   int'(x1), int'(!cxv[1]));
      if (cxv[0]) chk("R7 c0 kind", int'(k0), cxk[0]);
      if (cxv[1]) chk("R8 c1 kind", int'(k1), cxk[1]);
      if (cseen[0]) chk("R10 c0 rd_data", int'(q0), cexp[0]);
      if (cseen[1]) chk("R10 c1 rd_data", int'(q1), cexp[1]);
    end
  end

  // watchdog
  always @(posedge clk) begin
    ncyc++;
    if (ncyc > LIMIT && !finished) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", ncyc, LIMIT);
      wrap_up();
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [8:0] nxt();
    seq++;
    return 9'((seq * 37 + 11) & 9'h1ff);
  endfunction

  task automatic s_op(input bit w, input bit r, input bit t);
    s_wr = w; s_wd = nxt(); s_rd = r; s_rt = t;
    @(negedge clk);
  endtask

  task automatic c_op(input bit w, input bit r, input bit t);
    c_wr = w; c_wd = nxt(); c_rd = r; c_rt = t;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // reset state checked by the comparator (R1, R2, R3, R6)
    s_op(0, 0, 0);
    // standalone: mixed traffic (R1, R11)
    for (int i = 0; i < 5; i++) s_op(1, 0, 0);
    for (int i = 0; i < 2; i++) s_op(0, 1, 0);
    for (int i = 0; i < 6; i++) s_op(1, 1, 0);
    // fill past full, extra writes dropped (R2, R4)
    for (int i = 0; i < 20; i++) s_op(1, 0, 0);
    // write flow-through at full (R2)
    for (int i = 0; i < 4; i++) s_op(1, 1, 0);
    // drain past empty (R3)
    for (int i = 0; i < 20; i++) s_op(0, 1, 0);
    // read flow-through from empty (R3, R11)
    s_op(1, 0, 0);
    s_op(0, 1, 0);
    s_op(0, 1, 0);
    // retransmit (R5)
    for (int i = 0; i < 6; i++) s_op(1, 0, 0);
    s_op(0, 0, 1);
    for (int i = 0; i < 10; i++) s_op(0, 1, 0);
    s_op(1, 1, 1);
    for (int i = 0; i < 4; i++) s_op(1, 1, 0);
    for (int i = 0; i < 20; i++) s_op(1, 0, 0);
    s_op(0, 0, 1);
    for (int i = 0; i < 18; i++) s_op(0, 1, 0);
    s_op(0, 0, 0);

    // ring: write token crosses to the second slice (R6, R7)
    for (int i = 0; i < 20; i++) c_op(1, 0, 0);
    // reads with retransmit requested, which must be ignored (R9)
    for (int i = 0; i < 10; i++) c_op(0, 1, (i % 3) == 0);
    // concurrent traffic, read token crosses (R8, R10)
    for (int i = 0; i < 30; i++) c_op(1, 1, 0);
    // fill the whole ring and past it (R10)
    for (int i = 0; i < 40; i++) c_op(1, 0, 0);
    // drain the whole ring and past it (R10)
    for (int i = 0; i < 40; i++) c_op(0, 1, i == 5);
    c_op(0, 0, 0);
    c_op(0, 0, 0);
    wrap_up();
  end
endmodule